// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the home directory for a group of memory blocks in a shared-memory machine whose nodes talk over a point-to-point network. There is no bus to snoop, so the directory keeps a state and a vector of sharing nodes for each block. It is the single point that puts competing requests in order. Requests arrive on one channel. Replies from nodes arrive on a second channel: invalidation acknowledgements and owner data. All outgoing messages leave through one small FIFO with a valid/ready handshake.

A read gets data back from the directory, unless another node holds the block modified. A write or an upgrade first removes every other copy. The directory invalidates the sharers and counts their acknowledgements, or it forwards the request to the owner and passes the owner's data on. While a block waits for replies it is busy, and new requests to it wait at the input until the transaction closes. The reply channel takes priority over the request channel, so that waiting transactions can always finish.

Top module: `dir_home`

## Requirements
- R1: Each block entry is uncached (empty sharer set), shared (at least one sharer) or modified (exactly one sharer, the owner). After reset every entry is uncached, `out_valid` is 0 and `req_ready` is 1.
- R2: A read (`req_type`=0) to an uncached or shared block emits DATA (`out_type`=0) to the requester at that block's address. The requester joins the sharer set.
- R3: A write (`req_type`=1) to an uncached block, or to a block the requester already owns, emits DATA to the requester. The requester becomes the owner.
- R4: An upgrade (`req_type`=2) from a current sharer emits INV (`out_type`=2) to every other sharer, lowest node number first. GRANT (`out_type`=1) goes to the requester after all acknowledgements (`rsp_type`=0) arrive. A sole sharer gets GRANT at once. The requester becomes the owner.
- R5: A write, or an upgrade from a node that is not a sharer, to a shared block invalidates all other sharers as in R4. When the last acknowledgement arrives it emits DATA instead of GRANT.
- R6: An acknowledgement counter is loaded with the number of invalidated sharers. No completion message is sent while any acknowledgement is outstanding.
- R7: A write or upgrade to a block modified by another node emits FWD (`out_type`=3) to the owner. When owner data (`rsp_type`=1) arrives from the owner, it emits DATA to the requester, which becomes the owner.
- R8: A read to a block modified by another node emits FWD to the owner. Owner data then produces WB (`out_type`=4, `out_dst`=the previous owner) followed by DATA to the requester. Both nodes are left as sharers.
- R9: A request to a busy block is held with `req_ready` low until the transaction completes. Requests to other blocks are still served meanwhile.
- R10: An acknowledgement or owner data for a block with no matching open transaction, or owner data from a node that is not the owner, is consumed and has no effect.
- R11: An output message stays valid with unchanged fields while `out_ready` is low. Messages leave in the order they were produced.
- R12: When two sharers race to upgrade, the one accepted first wins. The loser's copy is invalidated, and its later upgrade is handled as a write to a block modified elsewhere (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_type | input | 2 | 0 read, 1 write, 2 upgrade |
| req_src | input | clog2(NODES) | Requesting node |
| req_addr | input | clog2(BLOCKS) | Block index |
| rsp_valid | input | 1 | Node reply present |
| rsp_ready | output | 1 | Reply accepted this cycle |
| rsp_type | input | 1 | 0 acknowledgement, 1 owner data |
| rsp_src | input | clog2(NODES) | Replying node |
| rsp_addr | input | clog2(BLOCKS) | Block index |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network takes the message |
| out_type | output | 3 | 0 DATA, 1 GRANT, 2 INV, 3 FWD, 4 WB |
| out_dst | output | clog2(NODES) | Destination node (previous owner for WB) |
| out_addr | output | clog2(BLOCKS) | Block index |

## Verification
The bench targets several corner cases:
- A non-sharer upgrade. A design that trusted the request type would send GRANT without data.
- A sole-sharer upgrade. It must not wait for acknowledgements that will never come.
- A premature completion after two of three acknowledgements, which would break write serialization.
- A read to a modified block. If the design forgets to keep the old owner as a sharer, a later upgrade sends too few invalidations.
- An upgrade race. A design that let both upgrades succeed would create two owners.
- Held requests to a busy block, and stray replies. A design that leaked either would corrupt the entry.
- Output held under backpressure.

// File: rtl/dir_home.sv
`timescale 1ns/1ps
module dir_home #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int QDEPTH = 4,
  localparam int NW = (NODES  > 1) ? $clog2(NODES)  : 1,
  localparam int AW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_type,
  input  logic [NW-1:0] req_src,
  input  logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic          rsp_type,
  input  logic [NW-1:0] rsp_src,
  input  logic [AW-1:0] rsp_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_type,
  output logic [NW-1:0] out_dst,
  output logic [AW-1:0] out_addr
);
  localparam int CW = $clog2(NODES + 1);
  localparam int QW = $clog2(QDEPTH + 1);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int MW = 3 + NW + AW;

  localparam logic [1:0] Q_WR = 2'd1, Q_UPG = 2'd2;
  localparam logic       R_ACK = 1'b0, R_OD = 1'b1;
  localparam logic [2:0] O_DATA = 3'd0, O_GRANT = 3'd1, O_INV = 3'd2, O_FWD = 3'd3, O_WB = 3'd4;
  localparam logic [1:0] S_UNC = 2'd0, S_SHR = 2'd1, S_MOD = 2'd2;
  localparam logic [1:0] K_UPG = 2'd0, K_WINV = 2'd1, K_FWR = 2'd2, K_FRD = 2'd3;
  localparam logic [1:0] E_IDLE = 2'd0, E_INV = 2'd1, E_TAIL = 2'd2;

  function automatic logic [NW-1:0] low_idx(input logic [NODES-1:0] m);
    low_idx = '0;
    for (int i = NODES - 1; i >= 0; i--) if (m[i]) low_idx = NW'(i);
  endfunction

  function automatic logic [CW-1:0] popc(input logic [NODES-1:0] m);
    popc = '0;
    for (int i = 0; i < NODES; i++) popc = popc + CW'(m[i]);
  endfunction

  logic [1:0]       st  [BLOCKS];
  logic [NODES-1:0] shr [BLOCKS];
  logic             bsy [BLOCKS];
  logic [1:0]       knd [BLOCKS];
  logic [NW-1:0]    prq [BLOCKS];
  logic [CW-1:0]    acn [BLOCKS];

  logic [1:0]       e_st;
  logic [NODES-1:0] e_mask;
  logic [AW-1:0]    e_addr;
  logic [NW-1:0]    e_dst;

  logic [MW-1:0] mem [QDEPTH];
  logic [PW-1:0] wp, rp;
  logic [QW-1:0] cnt;
  logic full, idle, take_rsp, take_req, pop;

  assign full      = (cnt == QW'(QDEPTH));
  assign idle      = (e_st == E_IDLE);
  assign take_rsp  = idle && !full && rsp_valid;
  assign rsp_ready = take_rsp;
  assign req_ready = idle && !full && !rsp_valid && !bsy[req_addr];
  assign take_req  = req_valid && req_ready;
  assign out_valid = (cnt != '0);
  assign pop       = out_valid && out_ready;
  assign {out_type, out_dst, out_addr} = mem[rp];

  logic [AW-1:0]    sel_a;
  logic [1:0]       c_st, c_kd;
  logic [NODES-1:0] c_sh, sbit, others, e_mnext;
  logic [NW-1:0]    c_pr, own;
  logic [CW-1:0]    c_ac;
  logic             push, we, go_inv, go_tail;
  logic [2:0]       p_type;
  logic [NW-1:0]    p_dst;
  logic [AW-1:0]    p_addr;
  logic [1:0]       w_st, w_kd;
  logic [NODES-1:0] w_sh;
  logic             w_bsy;
  logic [NW-1:0]    w_pr;
  logic [CW-1:0]    w_ac;

  assign e_mnext = e_mask & ~(NODES'(1) << low_idx(e_mask));

  always_comb begin
    sel_a  = take_rsp ? rsp_addr : req_addr;
    c_st   = st[sel_a];
    c_sh   = shr[sel_a];
    c_kd   = knd[sel_a];
    c_pr   = prq[sel_a];
    c_ac   = acn[sel_a];
    own    = low_idx(c_sh);
    sbit   = NODES'(1) << req_src;
    others = c_sh & ~sbit;
    push = 1'b0; p_type = O_DATA; p_dst = '0; p_addr = sel_a;
    we = 1'b0; w_st = c_st; w_sh = c_sh; w_bsy = bsy[sel_a];
    w_kd = c_kd; w_pr = c_pr; w_ac = c_ac;
    go_inv = 1'b0; go_tail = 1'b0;
    if (e_st == E_INV) begin
      if (!full) begin
        push = 1'b1; p_type = O_INV; p_dst = low_idx(e_mask); p_addr = e_addr;
      end
    end else if (e_st == E_TAIL) begin
      if (!full) begin
        push = 1'b1; p_type = O_DATA; p_dst = e_dst; p_addr = e_addr;
      end
    end else if (take_rsp) begin
      if (bsy[sel_a]) begin
        if (rsp_type == R_ACK && (c_kd == K_UPG || c_kd == K_WINV)) begin
          we = 1'b1;
          w_ac = c_ac - CW'(1);
          if (c_ac == CW'(1)) begin
            push = 1'b1; p_type = (c_kd == K_UPG) ? O_GRANT : O_DATA; p_dst = c_pr;
            w_st = S_MOD; w_sh = NODES'(1) << c_pr; w_bsy = 1'b0;
          end
        end else if (rsp_type == R_OD && rsp_src == own && c_kd == K_FWR) begin
          we = 1'b1; push = 1'b1; p_type = O_DATA; p_dst = c_pr;
          w_st = S_MOD; w_sh = NODES'(1) << c_pr; w_bsy = 1'b0;
        end else if (rsp_type == R_OD && rsp_src == own && c_kd == K_FRD) begin
          we = 1'b1; push = 1'b1; p_type = O_WB; p_dst = own; go_tail = 1'b1;
          w_st = S_SHR; w_sh = c_sh | (NODES'(1) << c_pr); w_bsy = 1'b0;
        end
      end
    end else if (take_req) begin
      we = 1'b1;
      w_pr = req_src;
      if (c_st == S_MOD && own != req_src) begin
        push = 1'b1; p_type = O_FWD; p_dst = own;
        w_bsy = 1'b1; w_kd = (req_type == Q_WR || req_type == Q_UPG) ? K_FWR : K_FRD;
      end else if (req_type != Q_WR && req_type != Q_UPG) begin
        push = 1'b1; p_type = O_DATA; p_dst = req_src;
        if (c_st != S_MOD) begin
          w_st = S_SHR; w_sh = c_sh | sbit;
        end
      end else if (c_st == S_SHR && others != '0) begin
        go_inv = 1'b1; w_bsy = 1'b1; w_ac = popc(others);
        w_kd = (req_type == Q_UPG && c_sh[req_src]) ? K_UPG : K_WINV;
      end else begin
        push = 1'b1; p_dst = req_src;
        p_type = (req_type == Q_UPG && c_st == S_SHR) ? O_GRANT : O_DATA;
        w_st = S_MOD; w_sh = sbit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st[b] <= S_UNC; shr[b] <= '0; bsy[b] <= 1'b0;
        knd[b] <= K_UPG; prq[b] <= '0; acn[b] <= '0;
      end
      e_st <= E_IDLE; e_mask <= '0; e_addr <= '0; e_dst <= '0;
    end else begin
      if (we) begin
        st[sel_a] <= w_st; shr[sel_a] <= w_sh; bsy[sel_a] <= w_bsy;
        knd[sel_a] <= w_kd; prq[sel_a] <= w_pr; acn[sel_a] <= w_ac;
      end
      case (e_st)
        E_INV: if (!full) begin
          e_mask <= e_mnext;
          if (e_mnext == '0) e_st <= E_IDLE;
        end
        E_TAIL: if (!full) e_st <= E_IDLE;
        default: begin
          if (go_inv) begin
            e_st <= E_INV; e_mask <= others; e_addr <= req_addr;
          end else if (go_tail) begin
            e_st <= E_TAIL; e_dst <= c_pr; e_addr <= rsp_addr;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= {p_type, p_dst, p_addr};
        wp <= (wp == PW'(QDEPTH - 1)) ? '0 : wp + PW'(1);
      end
      if (pop) rp <= (rp == PW'(QDEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + QW'(push) - QW'(pop);
    end
  end

  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_dst) && $stable(out_addr));
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= QW'(QDEPTH));

  for (genvar g = 0; g < BLOCKS; g++) begin : g_chk
    a_r1_mod_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] == S_MOD |-> $countones(shr[g]) == 1);
    a_r1_shr_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] == S_SHR |-> shr[g] != '0);
    a_r1_unc_empty: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] == S_UNC |-> shr[g] == '0);
    a_r6_ack_pending: assert property (@(posedge clk) disable iff (!rst_n)
      bsy[g] && (knd[g] == K_UPG || knd[g] == K_WINV) |-> acn[g] != '0);
  end
endmodule

// File: tb/sim_dir_home.sv
`timescale 1ns/1ps
module sim_dir_home;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_valid = 1'b0, out_ready = 1'b0, rsp_type = 1'b0;
  logic [1:0] req_type = '0, req_src = '0, rsp_src = '0;
  logic [2:0] req_addr = '0, rsp_addr = '0;
  logic req_ready, rsp_ready, out_valid;
  logic [2:0] out_type, out_addr;
  logic [1:0] out_dst;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dir_home #(.NODES(4), .BLOCKS(8), .QDEPTH(4)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_type, .req_src, .req_addr,
    .rsp_valid, .rsp_ready, .rsp_type, .rsp_src, .rsp_addr,
    .out_valid, .out_ready, .out_type, .out_dst, .out_addr);

  function automatic logic [13:0] v(int op, int ty, int nd, int ad, int rq);
    return {op[1:0], ty[2:0], nd[1:0], ad[2:0], rq[3:0]};
  endfunction

  // op 0 request, 1 reply, 2 expected message
  localparam int NV = 55;
  localparam logic [13:0] VEC [NV] = '{
    v(0,0,0,1,2), v(2,0,0,1,2), v(0,0,1,1,2), v(2,0,1,1,2),                 // R2
    v(0,2,1,1,4), v(2,2,0,1,4), v(1,0,0,1,4), v(2,1,1,1,4),                 // R4
    v(0,1,2,1,7), v(2,3,1,1,7), v(1,1,1,1,7), v(2,0,2,1,7),                 // R7
    v(0,0,3,1,8), v(2,3,2,1,8), v(1,1,2,1,8), v(2,4,2,1,8), v(2,0,3,1,8),   // R8
    v(0,2,3,1,8), v(2,2,2,1,8), v(1,0,2,1,8), v(2,1,3,1,8),
    v(0,1,0,2,3), v(2,0,0,2,3), v(0,1,0,2,3), v(2,0,0,2,3),                 // R3
    v(0,0,0,3,2), v(2,0,0,3,2), v(0,0,1,3,2), v(2,0,1,3,2), v(0,0,2,3,2), v(2,0,2,3,2),
    v(0,2,3,3,5), v(2,2,0,3,5), v(2,2,1,3,5), v(2,2,2,3,5),                 // R5
    v(1,0,0,3,5), v(1,0,1,3,5), v(1,0,2,3,5), v(2,0,3,3,5),
    v(0,0,0,4,4), v(2,0,0,4,4), v(0,2,0,4,4), v(2,1,0,4,4),                 // R4 sole sharer
    v(0,0,0,0,12), v(2,0,0,0,12), v(0,0,1,0,12), v(2,0,1,0,12),             // R12
    v(0,2,0,0,12), v(2,2,1,0,12), v(1,0,1,0,12), v(2,1,0,0,12),
    v(0,2,1,0,12), v(2,3,0,0,12), v(1,1,0,0,12), v(2,0,1,0,12)
  };

  task automatic check(input bit ok, input int rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic send_req(input int ty, input int nd, input int ad);
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(ty); req_src = 2'(nd); req_addr = 3'(ad);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic send_rsp(input int ty, input int nd, input int ad);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_type = 1'(ty); rsp_src = 2'(nd); rsp_addr = 3'(ad);
    #1;
    while (!rsp_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 rsp_valid = 1'b0;
  endtask

  task automatic expect_msg(input int ty, input int nd, input int ad, input int rq);
    int w = 0;
    @(negedge clk);
    while (!out_valid && w < 50) begin @(negedge clk); w++; end
    check(out_valid, rq, "message present", int'(out_valid), 1);
    if (out_valid) begin
      check(out_type == 3'(ty), rq, "out_type", int'(out_type), ty);
      check(out_dst == 2'(nd), rq, "out_dst", int'(out_dst), nd);
      check(out_addr == 3'(ad), rq, "out_addr", int'(out_addr), ad);
      out_ready = 1'b1;
      @(posedge clk); #1 out_ready = 1'b0;
    end
  endtask

  task automatic expect_quiet(input int rq);
    repeat (6) @(negedge clk);
    check(!out_valid, rq, "no message", int'(out_valid), 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, 1, "reset out_valid", int'(out_valid), 0);   // R1
    check(req_ready, 1, "reset req_ready", int'(req_ready), 1);     // R1

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][13:12])
        2'd0: send_req(int'(VEC[i][11:9]), int'(VEC[i][8:7]), int'(VEC[i][6:4]));
        2'd1: send_rsp(int'(VEC[i][11:9]), int'(VEC[i][8:7]), int'(VEC[i][6:4]));
        default: expect_msg(int'(VEC[i][11:9]), int'(VEC[i][8:7]), int'(VEC[i][6:4]), int'(VEC[i][3:0]));
      endcase
    end

    // R6 and R9: three sharers on block 5, non-sharer upgrade
    for (int n = 0; n < 3; n++) begin send_req(0, n, 5); expect_msg(0, n, 5, 2); end
    send_req(2, 3, 5);
    for (int n = 0; n < 3; n++) expect_msg(2, n, 5, 5);
    send_rsp(0, 0, 5);
    send_rsp(0, 1, 5);
    expect_quiet(6);                                                 // R6 one ack outstanding
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'd0; req_src = 2'd1; req_addr = 3'd5;
    for (int k = 0; k < 3; k++) begin
      #1 check(!req_ready, 9, "busy block held", int'(req_ready), 0);   // R9
      @(negedge clk);
    end
    req_valid = 1'b0;
    send_req(0, 0, 6); expect_msg(0, 0, 6, 9);                       // R9 other block served
    send_rsp(0, 2, 5); expect_msg(0, 3, 5, 6);                       // R6 last ack completes
    send_req(0, 1, 5); expect_msg(3, 3, 5, 9);                       // R9 released, forwarded
    send_rsp(1, 3, 5); expect_msg(4, 3, 5, 8); expect_msg(0, 1, 5, 8);

    // R10: stray replies
    send_rsp(0, 2, 7);
    send_rsp(1, 1, 7);
    expect_quiet(10);
    send_req(0, 2, 7); expect_msg(0, 2, 7, 10);
    send_req(1, 3, 7); expect_msg(2, 2, 7, 10);
    send_rsp(1, 1, 7);                                               // R10 data from non-owner
    expect_quiet(10);
    send_rsp(0, 2, 7); expect_msg(0, 3, 7, 10);

    // R11: backpressure hold
    send_req(0, 2, 6);
    repeat (4) begin
      @(negedge clk);
      check(out_valid && out_dst == 2'd2 && out_type == 3'd0, 11, "held message", int'(out_dst), 2);
    end
    expect_msg(0, 2, 6, 11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule